// File: doc/BRIEF.md
# Bad-Block-Skipping Boot Image Loader

This block is the control core of a boot-time loader that copies an image of a given byte length out of raw NAND flash into memory. A single `start` pulse hands it the image length, the byte offset in flash where the image begins, and the memory address where it should land. The loader then walks the flash page by page. For every page it emits the byte-wide command and address sequence that a downstream page-read engine forwards to the flash. It then hands that engine one page request carrying the destination address, and waits for the engine's verdict: whether the page could be read, and the first two spare-area bytes.

Pages are grouped into erase blocks. The loader judges each block as a whole. A block is skipped when any readable page in it carries a factory bad-block marker, or when none of its pages can be read at all. An unreadable page inside a block that turns out to be usable is fatal and ends the load with an error. Only blocks judged good consume image length and advance the destination address. A skipped block is therefore overwritten in memory by the block that follows it. The flash page pointer still moves forward by one block's worth of pages for every block, good or bad. The data movement and the ECC are handled by the engine and are not part of this block.

Top module: `nand_boot_loader`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `nb_valid` and `pg_req` are all low.
- R2: Each page read is seven consecutive cycles of `nb_valid`, carrying these bytes in order: a command (`nb_addr`=0) 0x00, two address bytes (`nb_addr`=1) of 0x00, three address bytes giving the page number from its least to its most significant byte, and a command 0x30. `pg_req` is high for exactly one cycle, in the cycle right after the 0x30 byte.
- R3: The first page read is `img_offset / PAGE_BYTES`. Within a block the pages rise by one. Each block starts `BLK_PAGES` pages after the first page of the previous block, whether that block was kept or skipped.
- R4: The number of blocks loaded is `ceil(img_size / (PAGE_BYTES*BLK_PAGES))`. Within the remaining page budget `ceil(img_size / PAGE_BYTES)`, a block reads at most `BLK_PAGES` pages, and the final block reads only the pages still owed.
- R5: A readable page (`pg_ok`=1) whose `pg_spare0` or `pg_spare1` differs from 0xFF marks its block bad. No further page of that block is read, and the block is skipped even if earlier pages of it were unreadable.
- R6: A block in which every page read returns `pg_ok`=0 is skipped. The spare bytes of unreadable pages are ignored.
- R7: A block that has at least one readable page, no marker and at least one unreadable page ends the load with `error` high, and no further page is read.
- R8: Page k of a block is requested with `pg_dest` = D + k*`PAGE_BYTES`, where D is the current destination. D starts at `img_dest` and grows by the block's byte share (at most `PAGE_BYTES*BLK_PAGES`) only after a kept block.
- R9: When every required block has been loaded, `done` rises. `done` and `error` are never both high. Each stays high with no further activity until the next `start`. A zero `img_size` yields `done` without any page read.
- R10: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load with the request fields below (ignored while busy) |
| img_size | input | SIZE_W | Image length in bytes |
| img_offset | input | ADDR_W | Byte offset of the image in flash |
| img_dest | input | ADDR_W | Memory address of the first image byte |
| nb_valid | output | 1 | Command/address byte valid this cycle |
| nb_addr | output | 1 | 1: byte is an address byte, 0: command byte |
| nb_byte | output | 8 | Command or address byte |
| pg_req | output | 1 | One-cycle request to transfer the addressed page |
| pg_dest | output | ADDR_W | Memory address for the requested page |
| pg_ack | input | 1 | Page transfer finished (one cycle) |
| pg_ok | input | 1 | Page was readable |
| pg_spare0 | input | 8 | First spare-area byte of the page |
| pg_spare1 | input | 8 | Second spare-area byte of the page |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load finished successfully |
| error | output | 1 | Load aborted on a fatal page error |

## Verification
The byte sequence of R2 is due cycle by cycle, so the bench's engine model inspects `nb_valid` on every falling edge and flags any gap, wrong byte or early request. The model answers each `pg_req` one to three cycles later, varying the delay by read number, because the loader only advances on `pg_ack`. Page numbers, destinations and the final outcome depend only on the order of events and not on their exact cycle. The bench therefore records every request, waits for `done` or `error`, and compares the whole list against an arithmetic model of the block walk. It then idles a few more cycles to confirm the result holds and no stray read appears.

// File: rtl/nbl_pkg.sv
// Shared constants and state encoding for the boot image loader.
// Assumes an 8-bit flash command/address path.
package nbl_pkg;
    localparam logic [7:0] CMD_PAGE_READ  = 8'h00;
    localparam logic [7:0] CMD_READ_START = 8'h30;
    localparam logic [7:0] SPARE_ERASED   = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BLOCK,
        ST_SEQ,
        ST_REQ,
        ST_WAIT,
        ST_JUDGE,
        ST_DONE,
        ST_FAIL
    } ldr_state_t;
endpackage

// File: rtl/nbl_addr_seq.sv
// Emits the per-page command/address byte train: read command, column
// bytes (zero), row bytes (page number, LSB first), read-start command.
// Assumes en stays high until last is seen; the step counter restarts
// whenever en is low.
module nbl_addr_seq
    import nbl_pkg::*;
#(
    parameter int COL_BYTES = 2,
    parameter int ROW_BYTES = 3,
    localparam int ROW_W    = 8 * ROW_BYTES,
    localparam int SEQ_LEN  = COL_BYTES + ROW_BYTES + 2,
    localparam int STEP_W   = $clog2(SEQ_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [ROW_W-1:0] row,
    output logic             valid,
    output logic             is_addr,
    output logic [7:0]       data,
    output logic             last
);
    logic [STEP_W-1:0] step;

    // Step counter: runs while enabled, parks on the final byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            step <= '0;
        else if (step != STEP_W'(SEQ_LEN - 1))
            step <= step + 1'b1;
    end

    // Byte selection for the current step.
    always_comb begin
        is_addr = 1'b1;
        data    = 8'h00;
        if (step == '0) begin
            is_addr = 1'b0;
            data    = CMD_PAGE_READ;
        end else if (step == STEP_W'(SEQ_LEN - 1)) begin
            is_addr = 1'b0;
            data    = CMD_READ_START;
        end else begin
            for (int k = 0; k < ROW_BYTES; k++)
                if (step == STEP_W'(COL_BYTES + 1 + k))
                    data = row[8*k +: 8];
        end
    end

    assign valid = en;
    assign last  = en && (step == STEP_W'(SEQ_LEN - 1));

    a_r2_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        step < STEP_W'(SEQ_LEN));
    a_r2_starts_at_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> (!is_addr && data == CMD_PAGE_READ));
endmodule

// File: rtl/nbl_block_judge.sv
// Accumulates per-page results of one erase block and gives the
// verdict: bad (marker seen, or nothing readable) or fatal (some page
// unreadable in an otherwise usable block). Assumes clr precedes each block.
module nbl_block_judge
    import nbl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       upd,
    input  logic       ok,
    input  logic [7:0] spare0,
    input  logic [7:0] spare1,
    output logic       hit_marker,
    output logic       blk_bad,
    output logic       blk_fatal
);
    logic seen_good, seen_mark, seen_err;

    assign hit_marker = upd && ok && (spare0 != SPARE_ERASED || spare1 != SPARE_ERASED);

    // Sticky per-block flags, cleared at the start of each block.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            seen_good <= 1'b0;
            seen_mark <= 1'b0;
            seen_err  <= 1'b0;
        end else if (upd) begin
            seen_good <= seen_good | ok;
            seen_mark <= seen_mark | hit_marker;
            seen_err  <= seen_err | !ok;
        end
    end

    assign blk_bad   = seen_mark || !seen_good;
    assign blk_fatal = seen_err && !blk_bad;
endmodule

// File: rtl/nbl_progress.sv
// Load progress bookkeeping: remaining bytes/pages/blocks, destination and
// flash page base, plus the per-block cursor. Assumes power-of-two page
// and block sizes.
module nbl_progress #(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 32,
    parameter int PAGE_BYTES = 2048,
    parameter int BLK_PAGES  = 64,
    parameter int ROW_W      = 24,
    localparam int PG_SH     = $clog2(PAGE_BYTES),
    localparam int BLK_BYTES = PAGE_BYTES * BLK_PAGES,
    localparam int BLK_SH    = $clog2(BLK_BYTES),
    localparam int CNT_W     = $clog2(BLK_PAGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SIZE_W-1:0] size,
    input  logic [ADDR_W-1:0] offset,
    input  logic [ADDR_W-1:0] dest,
    input  logic              blk_open,
    input  logic              pg_step,
    input  logic              blk_keep,
    input  logic              blk_skip,
    output logic              no_blocks,
    output logic [ROW_W-1:0]  cur_page,
    output logic [ADDR_W-1:0] cur_dest,
    output logic              last_page
);
    logic [SIZE_W-1:0] bytes_left, pages_left, blocks_left;
    logic [ADDR_W-1:0] dst;
    logic [ROW_W-1:0]  base_pg;
    logic [CNT_W-1:0]  cnt, blk_pages;
    logic [SIZE_W-1:0] blk_bytes;
    logic [SIZE_W-1:0] pages_ceil, blocks_ceil;
    logic [CNT_W-1:0]  blk_pages_v;
    logic [SIZE_W-1:0] blk_bytes_v;

    assign pages_ceil  = SIZE_W'(size >> PG_SH)  + SIZE_W'(|size[PG_SH-1:0]);
    assign blocks_ceil = SIZE_W'(size >> BLK_SH) + SIZE_W'(|size[BLK_SH-1:0]);
    assign blk_pages_v = (pages_left < SIZE_W'(BLK_PAGES)) ? pages_left[CNT_W-1:0]
                                                           : CNT_W'(BLK_PAGES);
    assign blk_bytes_v = (bytes_left < SIZE_W'(BLK_BYTES)) ? bytes_left
                                                           : SIZE_W'(BLK_BYTES);

    // Whole-load counters: set on load, consumed only by kept blocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes_left  <= '0;
            pages_left  <= '0;
            blocks_left <= '0;
            dst         <= '0;
            base_pg     <= '0;
        end else if (load) begin
            bytes_left  <= size;
            pages_left  <= pages_ceil;
            blocks_left <= blocks_ceil;
            dst         <= dest;
            base_pg     <= ROW_W'(offset >> PG_SH);
        end else if (blk_keep) begin
            bytes_left  <= bytes_left - blk_bytes;
            pages_left  <= pages_left - SIZE_W'(blk_pages);
            blocks_left <= blocks_left - 1'b1;
            dst         <= dst + ADDR_W'(blk_bytes);
            base_pg     <= base_pg + ROW_W'(BLK_PAGES);
        end else if (blk_skip) begin
            base_pg     <= base_pg + ROW_W'(BLK_PAGES);
        end
    end

    // Per-block cursor: opened from the load counters, stepped per page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_page  <= '0;
            cur_dest  <= '0;
            cnt       <= '0;
            blk_pages <= '0;
            blk_bytes <= '0;
        end else if (blk_open) begin
            cur_page  <= base_pg;
            cur_dest  <= dst;
            cnt       <= blk_pages_v;
            blk_pages <= blk_pages_v;
            blk_bytes <= blk_bytes_v;
        end else if (pg_step) begin
            cur_page  <= cur_page + 1'b1;
            cur_dest  <= cur_dest + ADDR_W'(PAGE_BYTES);
            cnt       <= cnt - 1'b1;
        end
    end

    assign no_blocks = (blocks_left == '0);
    assign last_page = (cnt == CNT_W'(1));

    a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(BLK_PAGES));
    a_r4_blocks_never_grow: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> blocks_left <= $past(blocks_left));
    a_r8_dest_only_on_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !blk_keep) |=> $stable(dst));
endmodule

// File: rtl/nand_boot_loader.sv
// Top of the boot image loader. Walks erase blocks from the start page,
// issues one command/address train and one page request per page, and
// keeps or skips each block from the engine's verdicts. Assumes the
// engine answers every pg_req with exactly one pg_ack.
module nand_boot_loader
    import nbl_pkg::*;
#(
    parameter int PAGE_BYTES = 2048,
    parameter int BLK_PAGES  = 64,
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 32,
    parameter int COL_BYTES  = 2,
    parameter int ROW_BYTES  = 3,
    localparam int ROW_W     = 8 * ROW_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SIZE_W-1:0] img_size,
    input  logic [ADDR_W-1:0] img_offset,
    input  logic [ADDR_W-1:0] img_dest,
    output logic              nb_valid,
    output logic              nb_addr,
    output logic [7:0]        nb_byte,
    output logic              pg_req,
    output logic [ADDR_W-1:0] pg_dest,
    input  logic              pg_ack,
    input  logic              pg_ok,
    input  logic [7:0]        pg_spare0,
    input  logic [7:0]        pg_spare1,
    output logic              busy,
    output logic              done,
    output logic              error
);
    ldr_state_t state, nxt;
    logic load, blk_open, pg_step, blk_keep, blk_skip, jclr, jupd, seq_en;
    logic no_blocks, last_page, seq_last, hit_marker, blk_bad, blk_fatal;
    logic [ROW_W-1:0] cur_page;

    nbl_progress #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .PAGE_BYTES(PAGE_BYTES),
        .BLK_PAGES(BLK_PAGES), .ROW_W(ROW_W)
    ) u_prog (
        .clk(clk), .rst_n(rst_n), .load(load), .size(img_size),
        .offset(img_offset), .dest(img_dest), .blk_open(blk_open),
        .pg_step(pg_step), .blk_keep(blk_keep), .blk_skip(blk_skip),
        .no_blocks(no_blocks), .cur_page(cur_page), .cur_dest(pg_dest),
        .last_page(last_page)
    );

    nbl_addr_seq #(.COL_BYTES(COL_BYTES), .ROW_BYTES(ROW_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(seq_en), .row(cur_page),
        .valid(nb_valid), .is_addr(nb_addr), .data(nb_byte), .last(seq_last)
    );

    nbl_block_judge u_judge (
        .clk(clk), .rst_n(rst_n), .clr(jclr), .upd(jupd), .ok(pg_ok),
        .spare0(pg_spare0), .spare1(pg_spare1), .hit_marker(hit_marker),
        .blk_bad(blk_bad), .blk_fatal(blk_fatal)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // Next state and per-state control strobes.
    always_comb begin
        nxt      = state;
        load     = 1'b0;
        blk_open = 1'b0;
        pg_step  = 1'b0;
        blk_keep = 1'b0;
        blk_skip = 1'b0;
        jclr     = 1'b0;
        jupd     = 1'b0;
        seq_en   = 1'b0;
        case (state)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) begin
                    load = 1'b1;
                    nxt  = ST_BLOCK;
                end
            end
            ST_BLOCK: begin
                if (no_blocks) begin
                    nxt = ST_DONE;
                end else begin
                    blk_open = 1'b1;
                    jclr     = 1'b1;
                    nxt      = ST_SEQ;
                end
            end
            ST_SEQ: begin
                seq_en = 1'b1;
                if (seq_last)
                    nxt = ST_REQ;
            end
            ST_REQ: nxt = ST_WAIT;
            ST_WAIT: begin
                if (pg_ack) begin
                    jupd    = 1'b1;
                    pg_step = 1'b1;
                    nxt     = (hit_marker || last_page) ? ST_JUDGE : ST_SEQ;
                end
            end
            ST_JUDGE: begin
                if (blk_fatal) begin
                    nxt = ST_FAIL;
                end else begin
                    blk_skip = blk_bad;
                    blk_keep = !blk_bad;
                    nxt      = ST_BLOCK;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign pg_req = (state == ST_REQ);
    assign done   = (state == ST_DONE);
    assign error  = (state == ST_FAIL);
    assign busy   = !(state == ST_IDLE || state == ST_DONE || state == ST_FAIL);

    a_r2_req_after_start_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        pg_req |-> $past(nb_valid && !nb_addr && nb_byte == CMD_READ_START));
    a_r2_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pg_req |=> !pg_req);
    a_r5_marker_stops_block: assert property (@(posedge clk) disable iff (!rst_n)
        hit_marker |=> (!nb_valid && !pg_req));
    a_r7_error_from_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> $past(state == ST_JUDGE));
    a_r9_outcomes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));
    a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && !nb_valid));
endmodule

// File: tb/sim_nand_boot_loader.sv
// Bench: small geometry (16-byte pages, 4 pages per block), behavioural
// page engine with a per-page fault map, and an arithmetic model of the walk.
module sim_nand_boot_loader;
    localparam int PB  = 16;
    localparam int PPB = 4;
    localparam int BLK = PB * PPB;
    localparam int AW  = 32;
    localparam int SW  = 32;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [SW-1:0] img_size = '0;
    logic [AW-1:0] img_offset = '0, img_dest = '0;
    logic nb_valid, nb_addr, pg_req, busy, done, error;
    logic [7:0] nb_byte;
    logic [AW-1:0] pg_dest;
    logic pg_ack = 1'b0, pg_ok = 1'b0;
    logic [7:0] pg_spare0 = 8'hFF, pg_spare1 = 8'hFF;

    nand_boot_loader #(.PAGE_BYTES(PB), .BLK_PAGES(PPB), .ADDR_W(AW), .SIZE_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .img_size(img_size),
        .img_offset(img_offset), .img_dest(img_dest), .nb_valid(nb_valid),
        .nb_addr(nb_addr), .nb_byte(nb_byte), .pg_req(pg_req), .pg_dest(pg_dest),
        .pg_ack(pg_ack), .pg_ok(pg_ok), .pg_spare0(pg_spare0), .pg_spare1(pg_spare1),
        .busy(busy), .done(done), .error(error)
    );

    always #10 clk = ~clk;

    int n_tests = 0, n_fail = 0;
    bit okm[256];
    int mk[256];
    int exp_page[64], exp_dest[64], exp_n, exp_res;
    int got_page[64], got_dest[64], got_n, seq_idx, seq_err;
    logic [7:0] rowb[3];
    bit pend;
    int dly, ack_pg;

    // Engine model and byte-train monitor, all on the falling edge.
    always @(negedge clk) begin
        pg_ack = 1'b0;
        if (pend) begin
            if (dly == 0) begin
                pg_ack = 1'b1;
                pg_ok  = okm[ack_pg & 255];
                if (!okm[ack_pg & 255]) begin
                    pg_spare0 = 8'h5A; pg_spare1 = 8'h00;
                end else if (mk[ack_pg & 255] == 1) begin
                    pg_spare0 = 8'h00; pg_spare1 = 8'hFF;
                end else if (mk[ack_pg & 255] == 2) begin
                    pg_spare0 = 8'hFF; pg_spare1 = 8'h7F;
                end else begin
                    pg_spare0 = 8'hFF; pg_spare1 = 8'hFF;
                end
                pend = 1'b0;
            end else begin
                dly--;
            end
        end
        if (rst_n) begin
            if (nb_valid) begin
                case (seq_idx)
                    0:       if (nb_addr || nb_byte != 8'h00) seq_err++;
                    1, 2:    if (!nb_addr || nb_byte != 8'h00) seq_err++;
                    3, 4, 5: if (!nb_addr) seq_err++; else rowb[seq_idx-3] = nb_byte;
                    6:       if (nb_addr || nb_byte != 8'h30) seq_err++;
                    default: seq_err++;
                endcase
                seq_idx++;
            end else if (pg_req) begin
                if (seq_idx != 7) seq_err++;
                seq_idx = 0;
                ack_pg = int'({rowb[2], rowb[1], rowb[0]});
                if (got_n < 64) begin
                    got_page[got_n] = ack_pg;
                    got_dest[got_n] = int'(pg_dest);
                end
                got_n++;
                pend = 1'b1;
                dly  = got_n % 3;
            end else if (seq_idx != 0) begin
                seq_err++;
                seq_idx = 0;
            end
        end
    end

    task automatic chk(input bit cond, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_map();
        for (int p = 0; p < 256; p++) begin
            okm[p] = 1'b1;
            mk[p]  = 0;
        end
    endtask

    // Arithmetic model of the block walk: expected reads and outcome (1 done, 2 error).
    task automatic ref_run(input int size, input int offs, input int dest);
        int bl, pl, bk, page, d, bb, bpl, cnt, bp, bd, guard;
        bit good, bad, err;
        bl = size; pl = (size + PB - 1) / PB; bk = (size + BLK - 1) / BLK;
        page = offs / PB; d = dest; exp_n = 0; exp_res = 1; guard = 0;
        while (bk > 0 && guard < 40) begin
            guard++;
            bb  = (bl < BLK) ? bl : BLK;
            bpl = (pl < PPB) ? pl : PPB;
            good = 0; bad = 0; err = 0; cnt = bpl; bp = page; bd = d;
            while (cnt > 0 && !bad) begin
                if (exp_n < 64) begin
                    exp_page[exp_n] = bp;
                    exp_dest[exp_n] = bd;
                end
                exp_n++;
                if (okm[bp & 255]) begin
                    good = 1;
                    if (mk[bp & 255] != 0) bad = 1;
                end else begin
                    err = 1;
                end
                bp++; bd += PB; cnt--;
            end
            if (!good) bad = 1;
            if (err && !bad) begin
                exp_res = 2;
                return;
            end
            if (!bad) begin
                d += bb; bl -= bb; pl -= bpl; bk--;
            end
            page += PPB;
        end
    endtask

    task automatic run_case(input int size, input int offs, input int dest,
                            input string req, input bit poke);
        int cyc, mism, res, n_end;
        ref_run(size, offs, dest);
        @(negedge clk);
        rst_n = 1'b0; pend = 1'b0; seq_idx = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        got_n = 0; seq_err = 0;
        img_size = SW'(size); img_offset = AW'(offs); img_dest = AW'(dest);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            img_size = '0; img_offset = AW'(200 * PB); img_dest = '0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (!(done || error) && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc < 20000, req, "watchdog cycles", cyc, 20000);
        mism = 0;
        for (int i = 0; i < 64 && i < exp_n && i < got_n; i++)
            if (got_page[i] != exp_page[i] || got_dest[i] != exp_dest[i]) mism++;
        chk(got_n == exp_n, req, "page reads", got_n, exp_n);
        chk(mism == 0, req, "page/dest mismatches", mism, 0);
        res = done ? 1 : (error ? 2 : 0);
        chk(res == exp_res, req, "outcome (1 done, 2 error)", res, exp_res);
        n_end = got_n;
        repeat (4) @(negedge clk);
        res = (done ? 1 : 0) + (error ? 2 : 0);
        chk(res == exp_res && got_n == n_end && !busy, "R9", "held outcome", res, exp_res);
        chk(seq_err == 0, "R2", "byte train errors", seq_err, 0);
    endtask

    initial begin
        clear_map();
        pend = 1'b0; seq_idx = 0; got_n = 0; seq_err = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !error, "R1", "status after reset", {busy, done, error}, 0);
        chk(!nb_valid && !pg_req, "R1", "engine port idle", {nb_valid, pg_req}, 0);

        // R9: zero-length image
        run_case(0, 0, 32'h1000, "R9", 1'b0);
        // R4: size sweep over clean flash
        foreach (exp_page[i]) exp_page[i] = 0;
        for (int s = 0; s < 10; s++) begin
            int sz;
            case (s)
                0: sz = 1;    1: sz = 16;  2: sz = 17;  3: sz = 63;  4: sz = 64;
                5: sz = 65;   6: sz = 100; 7: sz = 128; 8: sz = 129; default: sz = 200;
            endcase
            run_case(sz, 0, 32'h1000, "R4", 1'b0);
        end
        // R3: offset sweep, including offsets not aligned to a block
        for (int o = 0; o < 5; o++)
            run_case(150, o * 24, 32'h2000, "R3", 1'b0);

        // R5 / R7: single fault at each page of a three-block load
        for (int t = 0; t < 2; t++)
            for (int p = 0; p < 12; p++) begin
                clear_map();
                if (t == 0) okm[p] = 1'b0; else mk[p] = 1 + (p % 2);
                run_case(160, 0, 32'h1000, (t == 0) ? "R7" : "R5", 1'b0);
            end

        // R6: fully unreadable block with junk spares is skipped, R8 dest reused
        clear_map();
        for (int p = 4; p < 8; p++) okm[p] = 1'b0;
        run_case(192, 0, 32'h3000, "R6", 1'b0);
        chk(got_n > 8 && got_dest[8] == 32'h3040, "R8", "dest after skipped block",
            got_dest[8], 32'h3040);

        // R5: unreadable page then marker in same block -> skipped, not fatal
        clear_map();
        okm[5] = 1'b0; mk[7] = 2;
        run_case(128, 0, 32'h1000, "R5", 1'b0);
        // R5: marker then unreadable page -> stops at marker
        clear_map();
        mk[4] = 1; okm[5] = 1'b0;
        run_case(128, 0, 32'h1000, "R5", 1'b0);
        // R7: error in the final partial block
        clear_map();
        okm[6] = 1'b0;
        run_case(100, 0, 32'h1000, "R7", 1'b0);
        // R8: two consecutive bad blocks with an offset start
        clear_map();
        mk[9] = 1; okm[12] = 1'b0; okm[13] = 1'b0; okm[14] = 1'b0; okm[15] = 1'b0;
        run_case(120, 8 * PB, 32'h4000, "R8", 1'b0);
        // R10: start while busy is ignored
        clear_map();
        run_case(128, 0, 32'h1000, "R10", 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Global watchdog: an overlong run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d cycles", 190000, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule